// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

An 8-bit up-counter advances on one of four prescaled enable inputs, picked by a field in its mode register. A raw capture input first passes a two-flop synchronizer and then a debounce filter, which is clocked by a separate sampling enable. Each rising edge of the filtered level stores the running count in a rise-capture register. Each falling edge stores it in a fall-capture register. Edges can also clear the counter, on rising edges, on falling edges or on both, as a second field chooses.

A wrap from all-ones to zero sets one of two sticky overflow flags. Which flag is set depends on the filtered level at the moment of the wrap. A sticky request flag collects the chosen capture edge and, if enabled, the overflows. The interrupt output is that request gated by an enable bit. Software reaches everything through a small synchronous register port. When capture is switched off, the block runs as a plain interval timer.

Top module: `capTimer`

## Requirements
- R1: After reset the mode register (address 0), counter (address 1), rise capture (address 2), fall capture (address 3) and flag register (address 4) all read 0, and `irq` is low.
- R2: The counter increases by one, modulo 256, in every cycle in which `tickEn[clkSel]` is high. `clkSel` is mode bits 2:1 and is 0 after reset.
- R3: The filtered level changes only after the synchronized input has differed from it on 4 consecutive cycles with `sampleTick` high. A shorter run, or any matching sample, restarts the count.
- R4: With capture enabled (mode bit 6 = 1), a filtered rising edge copies the counter into address 2 and a filtered falling edge copies it into address 3. With bit 6 = 0, edges cause no capture, no clear and no edge request.
- R5: Mode bits 4:3 select the clear: 00 never, 01 on rising edges, 10 on falling edges, 11 on both. On a clearing edge the capture register gets the count from before the clear, and the counter then reads 0. A clear wins over an increment, and a clear in the cycle of a wrap suppresses the overflow flag.
- R6: A wrap of the counter from 0xFF to 0x00 sets flag bit 0 if the filtered level is high and capture is enabled. Otherwise it sets flag bit 1.
- R7: Flag bit 2 (request) is set by a filtered edge that matches mode bit 0 (1 = rising, 0 = falling). It is also set by any wrap while mode bit 5 is 1.
- R8: `irq` is high exactly when flag bit 2 and mode bit 7 are both 1.
- R9: Flags are sticky. A write to address 4 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1. A set in the same cycle wins over the clear.
- R10: A write to address 1 loads the counter. It overrides clear and increment and sets no overflow flag. Writes to addresses 2 and 3 have no effect.
- R11: Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rawIn | input | 1 | Unsynchronized capture input |
| sampleTick | input | 1 | Sampling enable for the noise filter |
| tickEn | input | 4 | Prescaled count enables; index 0 is the divide-by-64 rate |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge: a clearing capture edge and a counter wrap. The bench provokes this by loading the counter close to 0xFF with all enables running. It then toggles the input in runs of varied length, so that filtered edges fall on the wrap cycle over many trials. A behavioural model judges each such cycle. In that model the capture keeps the pre-clear count, the counter reads 0, and no overflow flag appears. Flag clears written in the same cycle as a flag set are judged the same way.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  localparam int ADDR_W     = 3;
  localparam int CLK_SEL_W  = 2;
  localparam int NUM_CLK    = 1 << CLK_SEL_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RCAP = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FCAP = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;

  localparam int FLAG_OVFH = 0;
  localparam int FLAG_OVFL = 1;
  localparam int FLAG_REQ  = 2;

  typedef struct packed {
    logic                 irqEn;
    logic                 capEn;
    logic                 ovfIe;
    logic [1:0]           clrMode;
    logic [CLK_SEL_W-1:0] clkSel;
    logic                 edgeRise;
  } modeT;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic capRise;
    logic capFall;
    logic setOvfH;
    logic setOvfL;
    logic setReq;
  } strobeT;
endpackage

// File: rtl/capFilter.sv
module capFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic sampleTick,
  output logic lvl,
  output logic flip
);
  localparam int RUN_W = $clog2(FILT_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [1:0]       syncQ;
  logic [RUN_W-1:0] run;
  logic             differ;

  assign differ = syncQ[1] ^ lvl;
  assign flip   = sampleTick & differ & (run == RUN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      run   <= '0;
      lvl   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (sampleTick) begin
        if (!differ) begin
          run <= '0;
        end else if (flip) begin
          lvl <= ~lvl;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
(
  input  modeT               mode,
  input  logic [NUM_CLK-1:0] tickEn,
  input  logic               lvl,
  input  logic               flip,
  input  logic               cntMax,
  input  logic               cpuCntWr,
  output strobeT             stb
);
  logic tick, rise, fall, clr, wrap, lvlEff;

  always_comb begin
    tick   = tickEn[mode.clkSel];
    rise   = flip & ~lvl & mode.capEn;
    fall   = flip &  lvl & mode.capEn;
    clr    = (rise & mode.clrMode[0]) | (fall & mode.clrMode[1]);
    wrap   = tick & cntMax & ~clr & ~cpuCntWr;
    lvlEff = lvl & mode.capEn;

    stb.cntInc  = tick & ~clr;
    stb.cntClr  = clr;
    stb.capRise = rise;
    stb.capFall = fall;
    stb.setOvfH = wrap & lvlEff;
    stb.setOvfL = wrap & ~lvlEff;
    stb.setReq  = (rise & mode.edgeRise) | (fall & ~mode.edgeRise) | (wrap & mode.ovfIe);
  end
endmodule

// File: rtl/capTimerDatapath.sv
module capTimerDatapath
  import capTimerPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output modeT              mode,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  riseCap,
  output logic [CNT_W-1:0]  fallCap,
  output logic              ovfH,
  output logic              ovfL,
  output logic              req,
  output logic              cntMax,
  output logic              cpuCntWr
);
  logic modeWr, flagWr;

  assign modeWr   = regWr && (regAddr == ADDR_MODE);
  assign flagWr   = regWr && (regAddr == ADDR_FLAG);
  assign cpuCntWr = regWr && (regAddr == ADDR_CNT);
  assign cntMax   = &cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= '0;
      cnt     <= '0;
      riseCap <= '0;
      fallCap <= '0;
      ovfH    <= 1'b0;
      ovfL    <= 1'b0;
      req     <= 1'b0;
    end else begin
      if (modeWr) mode <= modeT'(regWdata[7:0]);
      if (cpuCntWr)        cnt <= regWdata;
      else if (stb.cntClr) cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      if (stb.capRise) riseCap <= cnt;
      if (stb.capFall) fallCap <= cnt;
      ovfH <= (ovfH & ~(flagWr & ~regWdata[FLAG_OVFH])) | stb.setOvfH;
      ovfL <= (ovfL & ~(flagWr & ~regWdata[FLAG_OVFL])) | stb.setOvfL;
      req  <= (req  & ~(flagWr & ~regWdata[FLAG_REQ]))  | stb.setReq;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MODE: regRdata[7:0] = mode;
      ADDR_CNT:  regRdata = cnt;
      ADDR_RCAP: regRdata = riseCap;
      ADDR_FCAP: regRdata = fallCap;
      ADDR_FLAG: begin
        regRdata[FLAG_OVFH] = ovfH;
        regRdata[FLAG_OVFL] = ovfL;
        regRdata[FLAG_REQ]  = req;
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FILT_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rawIn,
  input  logic               sampleTick,
  input  logic [NUM_CLK-1:0] tickEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [CNT_W-1:0]   regWdata,
  output logic [CNT_W-1:0]   regRdata,
  output logic               irq
);
  modeT             mode;
  strobeT           stb;
  logic [CNT_W-1:0] cnt, riseCap, fallCap;
  logic             ovfH, ovfL, req, cntMax, cpuCntWr;
  logic             lvl, flip;

  capFilter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .sampleTick(sampleTick),
    .lvl(lvl), .flip(flip)
  );

  capTimerCtrl u_ctrl (
    .mode(mode), .tickEn(tickEn), .lvl(lvl), .flip(flip),
    .cntMax(cntMax), .cpuCntWr(cpuCntWr), .stb(stb)
  );

  capTimerDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .mode(mode), .cnt(cnt),
    .riseCap(riseCap), .fallCap(fallCap), .ovfH(ovfH), .ovfL(ovfL),
    .req(req), .cntMax(cntMax), .cpuCntWr(cpuCntWr)
  );

  assign irq = req & mode.irqEn;
endmodule

// File: rtl/capTimerChk.sv
module capTimerChk
  import capTimerPkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTick,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [CNT_W-1:0]  regWdata,
  input strobeT            stb,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  riseCap,
  input logic              ovfH,
  input logic              lvl,
  input logic              cpuCntWr
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntInc && !cpuCntWr) |=> (cnt == CNT_W'($past(cnt) + 1)));

  // R3
  filter_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lvl != $past(lvl)) |-> $past(sampleTick));

  // R4
  rise_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capRise |=> (riseCap == $past(cnt)));

  // R5
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntClr && !cpuCntWr) |=> (cnt == '0));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfH) |-> $past(regWr && regAddr == ADDR_FLAG && !regWdata[FLAG_OVFH]));

  // R10
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_CNT) |=> (cnt == $past(regWdata)));
endmodule

bind capTimer capTimerChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .regAddr(regAddr),
  .regWr(regWr), .regWdata(regWdata), .stb(stb), .cnt(cnt),
  .riseCap(riseCap), .ovfH(ovfH), .lvl(lvl), .cpuCntWr(cpuCntWr)
);

// File: tb/capTimer_tb.sv
module capTimer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rawIn = 1'b0;
  logic       sampleTick = 1'b0;
  logic [3:0] tickEn = 4'h0;
  logic [2:0] regAddr = 3'd0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit checkOn = 0;

  // knobs for the random phases
  int  maxHold = 8;
  bit  tickAll = 0;
  bit  sampAlways = 1;
  bit  cpuOps = 0;
  int  holdLeft = 0;
  int  rdAddr = 0;

  // behavioural reference state
  int mS1 = 0, mS2 = 0, mFilt = 0, mRun = 0;
  int mMode = 0, mCnt = 0, mRc = 0, mFc = 0, mFlags = 0;

  capTimer u_dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .sampleTick(sampleTick),
    .tickEn(tickEn), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin : model
    int tick, flip, capEn, rise, fall, clr, cw, fw, wrap, lvl;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mFilt = 0; mRun = 0;
      mMode = 0; mCnt = 0; mRc = 0; mFc = 0; mFlags = 0;
    end else begin
      tick  = (tickEn >> ((mMode >> 1) & 3)) & 1;
      flip  = (sampleTick && mS2 != mFilt && mRun == 3) ? 1 : 0;
      capEn = (mMode >> 6) & 1;
      rise  = (flip && !mFilt && capEn) ? 1 : 0;
      fall  = (flip && mFilt && capEn) ? 1 : 0;
      clr   = ((rise && ((mMode >> 3) & 1)) || (fall && ((mMode >> 4) & 1))) ? 1 : 0;
      cw    = (regWr && regAddr == 1) ? 1 : 0;
      fw    = (regWr && regAddr == 4) ? 1 : 0;
      wrap  = (tick && mCnt == 255 && !clr && !cw) ? 1 : 0;
      lvl   = (mFilt && capEn) ? 1 : 0;
      if (rise) mRc = mCnt;
      if (fall) mFc = mCnt;
      if (cw) mCnt = regWdata;
      else if (clr) mCnt = 0;
      else if (tick) mCnt = (mCnt + 1) % 256;
      if (fw) mFlags = mFlags & regWdata & 7;
      if (wrap) mFlags = mFlags | (lvl ? 1 : 2);
      if ((rise && (mMode & 1)) || (fall && !(mMode & 1)) || (wrap && ((mMode >> 5) & 1)))
        mFlags = mFlags | 4;
      if (regWr && regAddr == 0) mMode = regWdata;
      if (sampleTick) begin
        if (mS2 == mFilt) mRun = 0;
        else if (mRun == 3) begin mFilt = !mFilt; mRun = 0; end
        else mRun = mRun + 1;
      end
      mS2 = mS1;
      mS1 = rawIn;
    end
  end

  function automatic int expRead(int a);
    case (a)
      0: return mMode;
      1: return mCnt;
      2: return mRc;
      3: return mFc;
      4: return mFlags;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(int a);
    case (a)
      0: return "R1";
      1: return "R2 R5 R10";
      2: return "R4 R3";
      3: return "R4 R3";
      4: return "R6 R7 R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // compare the design against the model at the falling edge
  task automatic step();
    @(negedge clk);
    if (checkOn) begin
      check(tagOf(regAddr), regRdata, expRead(regAddr));
      check("R8", irq, ((mFlags >> 2) & 1) & ((mMode >> 7) & 1));
    end
  endtask

  task automatic writeReg(int a, int d);
    step();
    regWr = 1'b1; regAddr = 3'(a); regWdata = 8'(d);
    step();
    regWr = 1'b0;
  endtask

  task automatic runPhase(int n);
    for (int i = 0; i < n; i++) begin
      step();
      tickEn = tickAll ? 4'hF : 4'($urandom);
      sampleTick = sampAlways ? 1'b1 : 1'($urandom);
      if (holdLeft == 0) begin
        rawIn = ~rawIn;
        holdLeft = 1 + int'($urandom % maxHold);
      end
      holdLeft--;
      if (cpuOps && ($urandom % 16 == 0)) begin
        int pick = int'($urandom % 4);
        regWr = 1'b1;
        regAddr = (pick == 0) ? 3'd1 : (pick == 1) ? 3'd4 : (pick == 2) ? 3'd2 : 3'd3;
        if (pick == 0) regWdata = ($urandom % 2) ? 8'(8'hFC + $urandom % 4) : 8'($urandom);
        else regWdata = 8'($urandom);
      end else begin
        regWr = 1'b0;
        regAddr = 3'(rdAddr);
        rdAddr = (rdAddr + 1) % 8;
      end
    end
    step();
    regWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: every register reads zero after reset
    for (int a = 0; a < 5; a++) begin
      @(negedge clk);
      regAddr = 3'(a);
      #1;
      check("R1", regRdata, 0);
      check("R1", irq, 0);
    end
    checkOn = 1;

    // R2 R6: interval mode, rate 0 ticking every third cycle, wraps to low flag
    for (int i = 0; i < 800; i++) begin
      step();
      tickEn = (i % 3 == 0) ? 4'h1 : 4'h0;
      rawIn = 1'($urandom);
      regAddr = 3'(i % 8);
    end
    step();
    tickEn = 4'h0;
    regAddr = 3'd4;
    step();
    check("R6", regRdata, 2);

    // R3 R4 R5 R7 R8: capture on, clear on rise, rising request, rate 1
    writeReg(4, 0);
    writeReg(0, 8'b1110_1011);
    maxHold = 10; tickAll = 0; sampAlways = 1; cpuOps = 0;
    runPhase(2000);

    // R5 R9 R10: clear on both, falling request, all rates fast, cpu traffic
    writeReg(0, 8'b1111_1100);
    tickAll = 1; sampAlways = 0; cpuOps = 1; maxHold = 12;
    runPhase(2000);

    // R5: clear on fall with counter parked near wrap to hit edge+wrap cycles
    writeReg(0, 8'b1111_0101);
    sampAlways = 1; maxHold = 8;
    for (int k = 0; k < 60; k++) begin
      writeReg(1, 8'hFC + (k % 4));
      runPhase(20);
    end

    // R10: writes to capture addresses change nothing
    writeReg(2, 8'h5A);
    regAddr = 3'd2;
    step();
    check("R10", regRdata, mRc);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule